// File: doc/BRIEF.md
# Modem Handshake Control and Interrupt Request

This block holds the modem handshake control register of a serial port and the matching status view, and it produces the port's single interrupt request line. Software writes the control register to drive the two active-low handshake outputs: request-to-send (`rts_n`) and terminal-ready (`dtr_n`). The same register carries two interrupt enables. One is a global gate on the request line. The other lets modem line changes reach that line.

The two active-low modem inputs, clear-to-send (`cts_n`) and set-ready (`dsr_n`), are synchronised. Their asserted levels can be read in the status register. Every change of level, in either direction, latches a per-line change flag. A read of the status register clears the change flags. The interrupt request is the OR of three sources: the transmitter source, the receiver source, and the enabled modem change flags. The global enable then gates the result.

Register map, with `addr` compared in full: 0 selects the control register and 1 selects the status register. Every other address reads as zero and ignores writes.

Top module: `modem_irq_ctrl`

## Requirements
- R1: Writing control bit 0 as 1 drives `rts_n` low from the cycle after the write. Writing it as 0 drives `rts_n` high.
- R2: Writing control bit 1 as 1 drives `dtr_n` low from the cycle after the write. Writing it as 0 drives `dtr_n` high.
- R3: After reset the control register reads 0, `rts_n` and `dtr_n` are high, `intr` is low, and the status change flags (bits 2 and 3) read 0.
- R4: The control register reads back all `DATA_W` bits last written to it. A write to an unmapped address changes neither register.
- R5: Status bit 0 reads 1 while `cts_n` is low, and status bit 1 reads 1 while `dsr_n` is low. Each bit follows its input `SYNC_STAGES` cycles after the input changes. The other status bits above bit 3 read 0.
- R6: Any change of `cts_n` (falling or rising) sets status bit 2 within `SYNC_STAGES`+1 cycles. Any change of `dsr_n` sets status bit 3 in the same way.
- R7: A read of the status register (`rd_en` with address 1) returns the flags as they stand and clears them on the following cycle. A peek with `rd_en` low leaves them set.
- R8: While control bit 2 (global interrupt enable) is 0, `intr` stays low whatever the sources are.
- R9: With control bit 2 set, `intr` is high whenever `tx_irq_src` or `rx_irq_src` is high. It is also high when control bit 3 (modem interrupt enable) is set and a change flag is set.
- R10: With control bit 3 clear, modem change flags still latch but do not raise `intr`.
- R11: Changes of `dsr_n` or `cts_n` never alter `rts_n` or `dtr_n`. Those two outputs change only through control register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a status read clears the change flags) |
| addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, combinational |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Set-ready, active low, asynchronous |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| tx_irq_src | input | 1 | Transmitter interrupt source |
| rx_irq_src | input | 1 | Receiver interrupt source |
| intr | output | 1 | Interrupt request, active high |

## Verification
The assertions rely on two assumptions about the inputs:
- `wr_en` and `rd_en` are never both high in the same cycle.
- The modem inputs sit at their idle high level through reset, so the synchroniser starts in agreement with the pins.

The bench drives every strobe from its own task, one at a time, and holds `cts_n` and `dsr_n` high until reset ends. It moves a modem pin only at a falling clock edge and then waits at least `SYNC_STAGES`+2 cycles before it samples, so each latched change is observed after the full synchroniser delay.

// File: rtl/mic_pkg.sv
package mic_pkg;
   // control register bit positions
   localparam int CTRL_RTS  = 0;
   localparam int CTRL_DTR  = 1;
   localparam int CTRL_IEN  = 2;
   localparam int CTRL_MIEN = 3;
   // status register bit positions
   localparam int ST_CTS    = 0;
   localparam int ST_DSR    = 1;
   localparam int ST_DCTS   = 2;
   localparam int ST_DDSR   = 3;
   // modem line indices within the synchronised vector
   localparam int LINE_CTS  = 0;
   localparam int LINE_DSR  = 1;
   localparam int NUM_LINES = 2;

   typedef enum logic [1:0] {
      SEL_CTRL,
      SEL_STATUS,
      SEL_NONE
   } reg_sel_e;
endpackage

// File: rtl/mic_sync.sv
module mic_sync #(
   parameter int         STAGES  = 2,
   parameter int         WIDTH   = 2,
   parameter logic       RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mic_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mic_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= {WIDTH{RST_VAL}};
            else     chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= {WIDTH{RST_VAL}};
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mic_change_latch.sv
module mic_change_latch #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] lvl,
   input  logic             clr,
   output logic [WIDTH-1:0] flag
);
   if (WIDTH < 1) begin : g_bad_width
      $error("mic_change_latch: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] prev;
   logic [WIDTH-1:0] det;

   assign det = lvl ^ prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev <= '0;
         flag <= '0;
      end else begin
         prev <= lvl;
         // a fresh edge wins over a clear in the same cycle
         flag <= (flag & ~{WIDTH{clr}}) | det;
      end
   end

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      (|det) |=> ((flag & $past(det)) == $past(det)));

   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr && det == '0) |=> (flag == '0));

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr) |=> ((flag & $past(flag)) == $past(flag)));
endmodule

// File: rtl/mic_ctrl_reg.sv
module mic_ctrl_reg
   import mic_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              rts_n,
   output logic              dtr_n
);
   if (DATA_W < 4) begin : g_bad_width
      $error("mic_ctrl_reg: DATA_W must hold the four control bits");
   end

   always_ff @(posedge clk) begin
      if (rst)     ctrl_q <= '0;
      else if (we) ctrl_q <= wdata;
   end

   // a set bit asserts the pin, which is active low
   assign rts_n = ~ctrl_q[CTRL_RTS];
   assign dtr_n = ~ctrl_q[CTRL_DTR];

   // R1
   rts_follow_chk: assert property (@(posedge clk) disable iff (rst)
      we |=> (rts_n == !$past(wdata[CTRL_RTS])));

   // R2
   dtr_follow_chk: assert property (@(posedge clk) disable iff (rst)
      we |=> (dtr_n == !$past(wdata[CTRL_DTR])));

   // R11
   pins_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !we |=> ($stable(rts_n) && $stable(dtr_n)));
endmodule

// File: rtl/modem_irq_ctrl.sv
module modem_irq_ctrl
   import mic_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_INTR    = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cts_n,
   input  logic              dsr_n,
   output logic              rts_n,
   output logic              dtr_n,
   input  logic              tx_irq_src,
   input  logic              rx_irq_src,
   output logic              intr
);
   localparam logic [ADDR_W-1:0] ADDR_CTRL   = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(1);

   if (DATA_W < 4) begin : g_bad_data
      $error("modem_irq_ctrl: DATA_W must be at least 4");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("modem_irq_ctrl: ADDR_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("modem_irq_ctrl: SYNC_STAGES must be at least 2");
   end

   reg_sel_e                sel;
   logic [DATA_W-1:0]       ctrl_q;
   logic [NUM_LINES-1:0]    pins_q;
   logic [NUM_LINES-1:0]    lvl;
   logic [NUM_LINES-1:0]    chg;
   logic [DATA_W-1:0]       status;
   logic                    clr;
   logic                    intr_raw;

   always_comb begin
      if (addr == ADDR_CTRL)        sel = SEL_CTRL;
      else if (addr == ADDR_STATUS) sel = SEL_STATUS;
      else                          sel = SEL_NONE;
   end

   mic_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_en && sel == SEL_CTRL),
      .wdata  (wr_data),
      .ctrl_q (ctrl_q),
      .rts_n  (rts_n),
      .dtr_n  (dtr_n)
   );

   mic_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (NUM_LINES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({dsr_n, cts_n}),
      .q   (pins_q)
   );

   // asserted-high view of the active-low lines
   assign lvl = ~pins_q;
   assign clr = rd_en && sel == SEL_STATUS;

   mic_change_latch #(.WIDTH(NUM_LINES)) u_chg (
      .clk  (clk),
      .rst  (rst),
      .lvl  (lvl),
      .clr  (clr),
      .flag (chg)
   );

   always_comb begin
      status          = '0;
      status[ST_CTS]  = lvl[LINE_CTS];
      status[ST_DSR]  = lvl[LINE_DSR];
      status[ST_DCTS] = chg[LINE_CTS];
      status[ST_DDSR] = chg[LINE_DSR];
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL:   rd_data = ctrl_q;
         SEL_STATUS: rd_data = status;
         default:    rd_data = '0;
      endcase
   end

   assign intr_raw = ctrl_q[CTRL_IEN] &
                     (tx_irq_src | rx_irq_src | (ctrl_q[CTRL_MIEN] & (|chg)));

   if (REG_INTR) begin : g_intr_reg
      logic intr_q;
      always_ff @(posedge clk) begin
         if (rst) intr_q <= 1'b0;
         else     intr_q <= intr_raw;
      end
      assign intr = intr_q;

      // R8
      gate_off_chk: assert property (@(posedge clk) disable iff (rst)
         !ctrl_q[CTRL_IEN] |=> !intr);
      // R9
      modem_raise_chk: assert property (@(posedge clk) disable iff (rst)
         (ctrl_q[CTRL_IEN] && ctrl_q[CTRL_MIEN] && (|chg)) |=> intr);
   end else begin : g_intr_comb
      assign intr = intr_raw;

      // R8
      gate_off_chk: assert property (@(posedge clk) disable iff (rst)
         !ctrl_q[CTRL_IEN] |-> !intr);
      // R9
      modem_raise_chk: assert property (@(posedge clk) disable iff (rst)
         (ctrl_q[CTRL_IEN] && ctrl_q[CTRL_MIEN] && (|chg)) |-> intr);
      // R10
      modem_mask_chk: assert property (@(posedge clk) disable iff (rst)
         (!ctrl_q[CTRL_MIEN] && !tx_irq_src && !rx_irq_src) |-> !intr);
   end
endmodule

// File: tb/tb_modem_irq_ctrl.sv
`timescale 1ns/1ps
module tb_modem_irq_ctrl;
   localparam int DW = 8;
   localparam int AW = 2;
   localparam int SS = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          cts_n = 1'b1;
   logic          dsr_n = 1'b1;
   logic          rts_n;
   logic          dtr_n;
   logic          tx_irq_src = 1'b0;
   logic          rx_irq_src = 1'b0;
   logic          intr;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   modem_irq_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SS)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .cts_n(cts_n), .dsr_n(dsr_n),
      .rts_n(rts_n), .dtr_n(dtr_n), .tx_irq_src(tx_irq_src),
      .rx_irq_src(rx_irq_src), .intr(intr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
      @(negedge clk);
      addr = a; rd_en = 1'b0;
      #1 v = rd_data;
   endtask

   task automatic rd_clr(output logic [DW-1:0] v);
      @(negedge clk);
      addr = AW'(1); rd_en = 1'b1;
      #1 v = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (SS + 2) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      chk("R3 rts_n", rts_n, 1); chk("R3 dtr_n", dtr_n, 1); chk("R3 intr", intr, 0);
      peek(0, v); chk("R3 ctrl", v, 0);
      peek(1, v); chk("R3 flags", v[3:2], 0);
   endtask

   task automatic t_pins();
      wr(0, 8'h01); chk("R1 rts low", rts_n, 0); chk("R2 dtr idle", dtr_n, 1);
      wr(0, 8'h02); chk("R1 rts high", rts_n, 1); chk("R2 dtr low", dtr_n, 0);
      wr(0, 8'h00); chk("R2 dtr high", dtr_n, 1);
   endtask

   task automatic t_readback();
      logic [DW-1:0] v;
      wr(0, 8'hA3); peek(0, v); chk("R4 readback", v, 8'hA3);
      wr(2, 8'h5C); peek(0, v); chk("R4 unmapped write", v, 8'hA3);
      peek(2, v); chk("R4 unmapped read", v, 0);
      wr(0, 8'h00);
   endtask

   task automatic t_levels_and_change();
      logic [DW-1:0] v;
      rd_clr(v);
      @(negedge clk); cts_n = 1'b0;
      settle(); peek(1, v);
      chk("R5 cts level", v[0], 1); chk("R6 cts fall flag", v[2], 1);
      chk("R5 upper bits", v[DW-1:4], 0);
      chk("R10 masked intr", intr, 0);
      rd_clr(v); chk("R7 read returns flag", v[2], 1);
      peek(1, v); chk("R7 cleared", v[3:2], 0);
      @(negedge clk); cts_n = 1'b1;
      settle(); peek(1, v);
      chk("R5 cts released", v[0], 0); chk("R6 cts rise flag", v[2], 1);
      peek(1, v); chk("R7 peek keeps flag", v[2], 1);
      rd_clr(v);
      @(negedge clk); dsr_n = 1'b0;
      settle(); peek(1, v);
      chk("R5 dsr level", v[1], 1); chk("R6 dsr flag", v[3], 1);
      chk("R11 rts unaffected", rts_n, 1); chk("R11 dtr unaffected", dtr_n, 1);
      @(negedge clk); dsr_n = 1'b1; settle(); rd_clr(v);
   endtask

   task automatic t_interrupts();
      logic [DW-1:0] v;
      wr(0, 8'h00);
      @(negedge clk); tx_irq_src = 1'b1; rx_irq_src = 1'b1;
      #1 chk("R8 gated off", intr, 0);
      wr(0, 8'h04); chk("R9 tx+rx", intr, 1);
      @(negedge clk); tx_irq_src = 1'b0; #1 chk("R9 rx only", intr, 1);
      @(negedge clk); rx_irq_src = 1'b0; tx_irq_src = 1'b1; #1 chk("R9 tx only", intr, 1);
      @(negedge clk); tx_irq_src = 1'b0; #1 chk("R9 none", intr, 0);
      @(negedge clk); dsr_n = 1'b0; settle();
      chk("R10 modem masked", intr, 0);
      wr(0, 8'h0C); chk("R9 modem enabled", intr, 1);
      wr(0, 8'h08); chk("R8 master off", intr, 0);
      wr(0, 8'h0C); rd_clr(v); #1 chk("R7 intr drops on read", intr, 0);
      @(negedge clk); dsr_n = 1'b1; settle();
      chk("R9 dsr release", intr, 1);
      rd_clr(v); wr(0, 8'h00);
   endtask

   initial begin
      #500000;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_pins();
      t_readback();
      t_levels_and_change();
      t_interrupts();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule